// File: doc/BRIEF.md
# Data Address Generation Unit

This block works out the effective data-space address for a load or store. It is given an addressing mode, a choice of one of three 16-bit pointers, a 6-bit unsigned offset and a 16-bit absolute address. It names the register pair that holds the chosen pointer so that the register file can return the pointer bytes. One clock later it presents the effective address.

In the two auto-modify modes it also presents the updated pointer value, the index of the pair to write and a writeback strobe. Both pointer bytes are written back in the same cycle. Requests that do not make sense raise an illegal flag and never write anything back.

The pointers sit in general registers 26 to 31. Each pointer is held in an even/odd pair, with the low byte in the even register. Pointer arithmetic wraps within the 64 KiB space.

Top module: `dagu`

## Requirements
- R1: After reset is released, and before any request, out_valid, wb_en and illegal are 0, and ea and wb_data are 0.
- R2: A request with req_valid high on a clock edge gives out_valid high after that edge, with the results of that request. With no request, out_valid is 0 and ea, wb_data and illegal keep their previous values.
- R3: ptr_idx is combinational and names the even (low-byte) register of the selected pointer. The encoding is ptr_sel 0 = X (26), 1 = Y (28) and 2 = Z (30). The high byte lives at ptr_idx+1.
- R4: mode 0 (absolute) gives ea = dir_addr over the full range 0x0000 to 0xFFFF, with wb_en 0. This mode ignores ptr_sel, so ptr_sel 3 is not illegal here.
- R5: mode 1 (plain indirect) gives ea = {ptr_hi, ptr_lo}, with wb_en 0.
- R6: mode 2 (offset) with Y or Z gives ea = pointer + zero-extended disp (0 to 63) modulo 65536, with wb_en 0.
- R7: mode 3 (decrement first) gives ea = wb_data = pointer - 1 modulo 65536, with wb_en 1 and wb_idx = ptr_idx of that request.
- R8: mode 4 (increment after) gives ea = pointer and wb_data = pointer + 1 modulo 65536, with wb_en 1 and wb_idx = ptr_idx of that request.
- R9: Three kinds of request are illegal: mode 2 with X, mode codes 5 to 7, and ptr_sel 3 in any mode that uses a pointer (1 to 4). Such a request gives illegal 1, wb_en 0 and ea 0. A legal request gives illegal 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z |
| disp | input | 6 | Unsigned offset for mode 2 |
| dir_addr | input | 16 | Absolute address for mode 0 |
| ptr_idx | output | 5 | Register index of the selected pointer's low byte |
| ptr_lo | input | 8 | Low pointer byte from the register file |
| ptr_hi | input | 8 | High pointer byte from the register file |
| out_valid | output | 1 | Results below belong to the request of the previous cycle |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Write both pointer bytes back |
| wb_idx | output | 5 | Even register index of the pair to write |
| wb_data | output | 16 | Updated pointer value |
| illegal | output | 1 | Request was not a legal combination |

## Verification
The hardest cases to reach are the wrap boundaries of the pointer arithmetic. These are decrementing from 0x0000, incrementing from 0xFFFF, and an offset of 63 added to a pointer just below 0xFFFF. They occur only when exact byte pairs come back from the register file. The bench therefore drives ptr_hi and ptr_lo directly with these values and mixes them with illegal combinations, back-to-back requests and idle gaps. After the directed cases it runs an LFSR-driven sweep over every mode code and every pointer choice.

// File: rtl/dagu.sv
module dagu #(
  parameter int AW     = 16,
  parameter int DISP_W = 6,
  parameter int PBASE  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        mode,
  input  logic [1:0]        ptr_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     dir_addr,
  output logic [4:0]        ptr_idx,
  input  logic [AW/2-1:0]   ptr_lo,
  input  logic [AW/2-1:0]   ptr_hi,
  output logic              out_valid,
  output logic [AW-1:0]     ea,
  output logic              wb_en,
  output logic [4:0]        wb_idx,
  output logic [AW-1:0]     wb_data,
  output logic              illegal
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] ptr, n_ea, n_wb;
  logic          uses_ptr, bad, n_wen;

  assign ptr      = {ptr_hi, ptr_lo};
  assign ptr_idx  = 5'(PBASE) + 5'({ptr_sel, 1'b0});
  assign uses_ptr = (mode >= 3'd1) && (mode <= 3'd4);
  assign bad      = (mode > 3'd4) || (uses_ptr && ptr_sel == 2'd3) ||
                    (mode == 3'd2 && ptr_sel == 2'd0);

  always_comb begin
    n_ea  = '0;
    n_wb  = wb_data;
    n_wen = 1'b0;
    if (!bad) begin
      case (mode)
        3'd0: n_ea = dir_addr;
        3'd1: n_ea = ptr;
        3'd2: n_ea = ptr + AW'(disp);
        3'd3: begin n_ea = ptr - ONE; n_wb = ptr - ONE; n_wen = 1'b1; end
        3'd4: begin n_ea = ptr;       n_wb = ptr + ONE; n_wen = 1'b1; end
        default: n_ea = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= req_valid;
      wb_en     <= req_valid && n_wen;
      if (req_valid) begin
        ea      <= n_ea;
        wb_data <= n_wb;
        wb_idx  <= ptr_idx;
        illegal <= bad;
      end
    end
  end
endmodule

module dagu_chk #(
  parameter int AW     = 16,
  parameter int DISP_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        mode,
  input logic [1:0]        ptr_sel,
  input logic [DISP_W-1:0] disp,
  input logic [AW-1:0]     dir_addr,
  input logic [AW/2-1:0]   ptr_lo,
  input logic [AW/2-1:0]   ptr_hi,
  input logic              out_valid,
  input logic [AW-1:0]     ea,
  input logic              wb_en,
  input logic [AW-1:0]     wb_data,
  input logic              illegal
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !wb_en && $stable(ea)));
  assert_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd0) |=> (ea == $past(dir_addr) && !wb_en && !illegal));
  assert_predec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd3 && ptr_sel != 2'd3) |=>
      (wb_en && ea == wb_data && ea == $past({ptr_hi, ptr_lo}) - AW'(1)));
  assert_postinc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd4 && ptr_sel != 2'd3) |=>
      (wb_en && ea == $past({ptr_hi, ptr_lo}) && wb_data == ea + AW'(1)));
  assert_disp_x_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 3'd2 && ptr_sel == 2'd0) |=> (illegal && !wb_en));
  assert_no_wb_when_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en);
endmodule

bind dagu dagu_chk #(.AW(AW), .DISP_W(DISP_W)) u_dagu_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .ptr_sel(ptr_sel),
  .disp(disp), .dir_addr(dir_addr), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
  .out_valid(out_valid), .ea(ea), .wb_en(wb_en), .wb_data(wb_data), .illegal(illegal));

// File: tb/dagu_bench.sv
module dagu_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] ea;
    logic        wen;
    logic [4:0]  idx;
    logic [15:0] wdat;
    logic        ill;
    logic [3:0]  req;
  } exp_t;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [2:0] mode = 0;
  logic [1:0] ptr_sel = 0;
  logic [5:0] disp = 0;
  logic [15:0] dir_addr = 0;
  logic [7:0] ptr_lo = 0, ptr_hi = 0;
  logic [4:0] ptr_idx, wb_idx;
  logic out_valid, wb_en, illegal;
  logic [15:0] ea, wb_data;

  int vectors = 0, errors = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dagu u_dagu (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .ptr_sel(ptr_sel), .disp(disp), .dir_addr(dir_addr), .ptr_idx(ptr_idx),
    .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .out_valid(out_valid), .ea(ea),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal));

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  logic [15:0] last_wdat = 0;

  task automatic drive(input logic [2:0] m, input logic [1:0] s, input logic [5:0] d,
                       input logic [15:0] da, input logic [15:0] p);
    exp_t e;
    logic [15:0] pm1, pp1;
    logic [4:0] ix;
    bit up, bad;
    @(negedge clk);
    req_valid = 1; mode = m; ptr_sel = s; disp = d; dir_addr = da;
    ptr_lo = p[7:0]; ptr_hi = p[15:8];
    ix  = 5'(26 + 2 * s);
    pm1 = p - 16'd1; pp1 = p + 16'd1;
    up  = (m >= 1 && m <= 4);
    bad = (m > 4) || (up && s == 3) || (m == 2 && s == 0);
    e = '{ea: 16'h0, wen: 1'b0, idx: ix, wdat: last_wdat, ill: bad, req: 4'd9};
    if (!bad) begin
      case (m)
        3'd0: begin e.ea = da; e.req = 4'd4; end
        3'd1: begin e.ea = p;  e.req = 4'd5; end
        3'd2: begin e.ea = p + {10'd0, d}; e.req = 4'd6; end
        3'd3: begin e.ea = pm1; e.wdat = pm1; e.wen = 1; e.req = 4'd7; end
        default: begin e.ea = p; e.wdat = pp1; e.wen = 1; e.req = 4'd8; end
      endcase
    end
    last_wdat = e.wdat;
    q.push_back(e);
    #1;
    if (s != 3) chk(ptr_idx == ix, "R3 ptr_idx", 32'(ptr_idx), 32'(ix));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      string r;
      if (q.size() == 0) chk(0, "R2 unexpected out_valid", 1, 0);
      else begin
        e = q.pop_front();
        case (e.req)
          4'd4: r = "R4"; 4'd5: r = "R5"; 4'd6: r = "R6";
          4'd7: r = "R7"; 4'd8: r = "R8"; default: r = "R9";
        endcase
        chk(ea == e.ea, {r, " ea"}, 32'(ea), 32'(e.ea));
        chk(wb_en == e.wen, {r, " wb_en"}, 32'(wb_en), 32'(e.wen));
        chk(illegal == e.ill, {r, " illegal"}, 32'(illegal), 32'(e.ill));
        if (e.wen) begin
          chk(wb_data == e.wdat, {r, " wb_data"}, 32'(wb_data), 32'(e.wdat));
          chk(wb_idx == e.idx, {r, " wb_idx"}, 32'(wb_idx), 32'(e.idx));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [15:0] hold;
    lfsr = 32'hACE1_1234;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!out_valid && !wb_en && !illegal, "R1 flags", {out_valid, wb_en, illegal}, 0);
    chk(ea == 0 && wb_data == 0, "R1 data", {ea, wb_data}, 0);

    drive(3'd0, 2'd3, 6'd0, 16'hFFFF, 16'h1234);   // R4 top of space, sel 3 ignored
    drive(3'd0, 2'd0, 6'd5, 16'h0000, 16'hBEEF);   // R4
    drive(3'd1, 2'd1, 6'd0, 16'h0, 16'h8001);      // R5
    drive(3'd2, 2'd2, 6'd63, 16'h0, 16'hFFF0);     // R6 wrap -> 0x002F
    drive(3'd2, 2'd1, 6'd0, 16'h0, 16'h0100);      // R6 zero offset
    drive(3'd3, 2'd0, 6'd0, 16'h0, 16'h0000);      // R7 wrap -> FFFF
    drive(3'd4, 2'd2, 6'd0, 16'h0, 16'hFFFF);      // R8 wrap -> 0
    drive(3'd2, 2'd0, 6'd7, 16'h0, 16'h1000);      // R9 offset with X
    drive(3'd6, 2'd1, 6'd0, 16'h0, 16'h2000);      // R9 bad mode
    drive(3'd4, 2'd3, 6'd0, 16'h0, 16'h3000);      // R9 sel 3
    drive(3'd3, 2'd1, 6'd0, 16'h0, 16'h4000);      // R7
    idle(1);
    hold = ea;
    idle(3);
    // R2 idle hold
    chk(!out_valid && !wb_en, "R2 idle valid", {out_valid, wb_en}, 0);
    chk(ea == hold, "R2 idle ea hold", 32'(ea), 32'(hold));

    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[2:0], lfsr[4:3], lfsr[10:5], lfsr[31:16], lfsr[26:11]);
      if (lfsr[12]) idle(1);
    end
    idle(3);
    chk(q.size() == 0, "R2 missing results", q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule